// File: doc/BRIEF.md
# Keyed Reset and Event Status Unit

This block is a small register slice that sits behind a serial-bus byte framer. The framer hands it byte writes and reads by address. The slice holds two reset-key bytes. Only when each key byte carries its own magic value does the slice raise a one-cycle request to the system reset controller. That request also wipes both keys, so a later reset needs a fresh pair of writes.

The slice also keeps four event bytes. Hardware sources elsewhere in the chip set bits in them, and the bus master clears bits by writing ones. A status byte sums the events up: one flag per event byte, plus a ready flag for plain commands and a ready flag for API calls. An interrupt-style alert line tells the bus master that at least one event is pending.

The revision and mode bytes are returned as constants. Their values come from parameters.

Top module: `rstkey_status_unit`

## Requirements
- R1: After a synchronous reset, the key bytes at 0x06 and 0x07 read 0x00 and the status byte at 0x08 reads 0xC0. All event bytes read 0x00, and `alert` and `sys_rst_req` are low.
- R2: Addresses 0x00 to 0x05 return the parameter constants (boot minor, boot major, firmware minor, firmware major, mode low, mode high). Writes to those addresses, and writes to the status byte 0x08, change nothing that is read back.
- R3: When 0x06 holds 0x55 and 0x07 holds 0xAA, `sys_rst_req` is high for exactly the one cycle after the edge that completed the pair. The two keys may be written in either order. Any other pair of values never raises it.
- R4: On the edge where `sys_rst_req` rises, both key bytes become 0x00. A key write on that same edge is discarded.
- R5: Status bit i (i = 0..3) is 1 exactly when the event byte at address 0x09+i is nonzero. Status bits 5 and 4 read 0.
- R6: A 1 on `evt_set[8*i+b]` sets bit b of the event byte at 0x09+i on that edge. Writing a byte to 0x09..0x0C clears the bits that are 1 in the written data. When a set and a clear hit the same bit on the same edge, the set wins.
- R7: `alert` goes high on the same edge that any event bit becomes set. It goes low on the same edge that the last set bit is cleared.
- R8: Status bit 6 (API ready) drops on `api_start` and rises on `api_done`. Status bit 7 (command ready) does the same with `cmd_start` and `cmd_done`. For each flag, a start wins over a done on the same edge.
- R9: `rdata` is registered: it shows the byte at the `addr` sampled on the previous edge. Addresses 0x0D to 0xFF read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 8 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| evt_set | input | 32 | Event set bits; byte i feeds the event register at 0x09+i |
| cmd_start | input | 1 | Command accepted pulse; clears the command ready flag |
| cmd_done | input | 1 | Command finished pulse; sets the command ready flag |
| api_start | input | 1 | API execute pulse; clears the API ready flag |
| api_done | input | 1 | API finished pulse; sets the API ready flag |
| sys_rst_req | output | 1 | One-cycle system reset request |
| alert | output | 1 | High while any event bit is set |

## Verification
Two collisions in this block resolve on a single edge.

The first is a hardware event set landing on the same bit that a write-one-to-clear targets. The bench drives both on the same clock. It then expects the bit still set, its status flag still set and `alert` still high.

The second is a key write arriving on the edge where the reset request fires. The bench writes 0x06 on the edge right after completing the key pair. It then expects the pulse, followed by 0x00 when 0x06 is read back.

A start/done pair on the API flag shares that single-edge shape, and the bench expects the flag to end busy.

// File: rtl/rstkey_pkg.sv
package rstkey_pkg;
  localparam int DW    = 8;
  localparam int AW    = 8;
  localparam int EVT_N = 4;

  localparam logic [AW-1:0] A_BOOT_LO = 8'h00;
  localparam logic [AW-1:0] A_BOOT_HI = 8'h01;
  localparam logic [AW-1:0] A_FW_LO   = 8'h02;
  localparam logic [AW-1:0] A_FW_HI   = 8'h03;
  localparam logic [AW-1:0] A_MODE_LO = 8'h04;
  localparam logic [AW-1:0] A_MODE_HI = 8'h05;
  localparam logic [AW-1:0] A_KEY_LO  = 8'h06;
  localparam logic [AW-1:0] A_KEY_HI  = 8'h07;
  localparam logic [AW-1:0] A_STATUS  = 8'h08;
  localparam logic [AW-1:0] A_EVT0    = 8'h09;

  localparam logic [DW-1:0] MAGIC_LO  = 8'h55;
  localparam logic [DW-1:0] MAGIC_HI  = 8'hAA;

  localparam int ST_CMD_BIT = 7;
  localparam int ST_API_BIT = 6;
  localparam logic [DW-1:0] STATUS_RESET = 8'hC0;
endpackage

// File: rtl/rk_key_guard.sv
module rk_key_guard
  import rstkey_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] key_lo,
  output logic [DW-1:0] key_hi,
  output logic          fire
);
  logic armed;
  assign armed = (key_lo == MAGIC_LO) && (key_hi == MAGIC_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_lo <= '0;
      key_hi <= '0;
      fire   <= 1'b0;
    end else begin
      fire <= armed;
      if (armed) begin
        key_lo <= '0;
        key_hi <= '0;
      end else begin
        if (wr_lo) key_lo <= wdata;
        if (wr_hi) key_hi <= wdata;
      end
    end
  end
endmodule

// File: rtl/rk_event_bank.sv
module rk_event_bank #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N*W-1:0] set_vec,
  input  logic [N-1:0]   clr_sel,
  input  logic [W-1:0]   clr_mask,
  output logic [N*W-1:0] ev_flat,
  output logic [N-1:0]   ev_any,
  output logic           alert
);
  logic [N*W-1:0] ev_nxt;

  for (genvar i = 0; i < N; i++) begin : g_evt
    logic [W-1:0] clr_bits;
    assign clr_bits = clr_sel[i] ? clr_mask : '0;
    assign ev_nxt[i*W +: W] = (ev_flat[i*W +: W] & ~clr_bits) | set_vec[i*W +: W];
    assign ev_any[i] = |ev_flat[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_flat <= '0;
      alert   <= 1'b0;
    end else begin
      ev_flat <= ev_nxt;
      alert   <= |ev_nxt;
    end
  end
endmodule

// File: rtl/rk_ready_flag.sv
module rk_ready_flag (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  output logic ready
);
  always_ff @(posedge clk) begin
    if (rst)        ready <= 1'b1;
    else if (start) ready <= 1'b0;
    else if (done)  ready <= 1'b1;
  end
endmodule

// File: rtl/rstkey_status_unit.sv
module rstkey_status_unit
  import rstkey_pkg::*;
#(
  parameter logic [7:0] BOOT_MINOR = 8'h03,
  parameter logic [7:0] BOOT_MAJOR = 8'h01,
  parameter logic [7:0] FW_MINOR   = 8'h12,
  parameter logic [7:0] FW_MAJOR   = 8'h02,
  parameter logic [7:0] MODE_LOW   = 8'h00,
  parameter logic [7:0] MODE_HIGH  = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [31:0] evt_set,
  input  logic        cmd_start,
  input  logic        cmd_done,
  input  logic        api_start,
  input  logic        api_done,
  output logic        sys_rst_req,
  output logic        alert
);
  logic [DW-1:0]      key_lo, key_hi;
  logic [EVT_N*DW-1:0] ev_flat;
  logic [EVT_N-1:0]   ev_any;
  logic [EVT_N-1:0]   clr_sel;
  logic               cmd_rdy, api_rdy;
  logic [DW-1:0]      status;
  logic [DW-1:0]      rd_nxt;

  rk_key_guard u_keys (
    .clk    (clk),
    .rst    (rst),
    .wr_lo  (wr_en && addr == A_KEY_LO),
    .wr_hi  (wr_en && addr == A_KEY_HI),
    .wdata  (wdata),
    .key_lo (key_lo),
    .key_hi (key_hi),
    .fire   (sys_rst_req)
  );

  for (genvar i = 0; i < EVT_N; i++) begin : g_clr
    assign clr_sel[i] = wr_en && (addr == AW'(int'(A_EVT0) + i));
  end

  rk_event_bank #(.N(EVT_N), .W(DW)) u_events (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (evt_set),
    .clr_sel  (clr_sel),
    .clr_mask (wdata),
    .ev_flat  (ev_flat),
    .ev_any   (ev_any),
    .alert    (alert)
  );

  rk_ready_flag u_cmd_rdy (
    .clk (clk), .rst (rst), .start (cmd_start), .done (cmd_done), .ready (cmd_rdy)
  );

  rk_ready_flag u_api_rdy (
    .clk (clk), .rst (rst), .start (api_start), .done (api_done), .ready (api_rdy)
  );

  always_comb begin
    status = '0;
    status[ST_CMD_BIT] = cmd_rdy;
    status[ST_API_BIT] = api_rdy;
    status[EVT_N-1:0]  = ev_any;
  end

  always_comb begin
    rd_nxt = '0;
    unique case (addr)
      A_BOOT_LO: rd_nxt = BOOT_MINOR;
      A_BOOT_HI: rd_nxt = BOOT_MAJOR;
      A_FW_LO:   rd_nxt = FW_MINOR;
      A_FW_HI:   rd_nxt = FW_MAJOR;
      A_MODE_LO: rd_nxt = MODE_LOW;
      A_MODE_HI: rd_nxt = MODE_HIGH;
      A_KEY_LO:  rd_nxt = key_lo;
      A_KEY_HI:  rd_nxt = key_hi;
      A_STATUS:  rd_nxt = status;
      default:   rd_nxt = '0;
    endcase
    for (int i = 0; i < EVT_N; i++) begin
      if (addr == AW'(int'(A_EVT0) + i)) rd_nxt = ev_flat[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/rstkey_status_chk.sv
module rstkey_status_chk (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  key_lo,
  input logic [7:0]  key_hi,
  input logic        sys_rst_req,
  input logic [31:0] ev_flat,
  input logic [31:0] evt_set,
  input logic        alert,
  input logic        api_start,
  input logic        api_done,
  input logic        api_rdy
);
  // R3
  key_match_chk: assert property (@(posedge clk) disable iff (rst)
    (key_lo == 8'h55 && key_hi == 8'hAA) |=> sys_rst_req);

  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> !sys_rst_req);

  // R4
  keys_wiped_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> (key_lo == 8'h00 && key_hi == 8'h00));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_set != 32'h0) |=> ((ev_flat & $past(evt_set)) == $past(evt_set)));

  // R7
  alert_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    alert == (ev_flat != 32'h0));

  // R8
  api_drop_chk: assert property (@(posedge clk) disable iff (rst)
    api_start |=> !api_rdy);

  // R8
  api_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (api_done && !api_start) |=> api_rdy);
endmodule

bind rstkey_status_unit rstkey_status_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .key_lo      (key_lo),
  .key_hi      (key_hi),
  .sys_rst_req (sys_rst_req),
  .ev_flat     (ev_flat),
  .evt_set     (evt_set),
  .alert       (alert),
  .api_start   (api_start),
  .api_done    (api_done),
  .api_rdy     (api_rdy)
);

// File: tb/test_rstkey_status_unit.sv
module test_rstkey_status_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [31:0] evt_set = '0;
  logic        cmd_start = 1'b0, cmd_done = 1'b0;
  logic        api_start = 1'b0, api_done = 1'b0;
  logic        sys_rst_req, alert;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] a;
    logic [7:0] e;
    string      tag;
  } sb_item_t;
  sb_item_t sb[$];

  always #10 clk = ~clk;

  rstkey_status_unit i_rstkey_status_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_set(evt_set), .cmd_start(cmd_start),
    .cmd_done(cmd_done), .api_start(api_start), .api_done(api_done),
    .sys_rst_req(sys_rst_req), .alert(alert)
  );

  // monitor: compare registered read data against the scoreboard
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.e) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.e);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    @(posedge clk);
    #1;
    it.a = a; it.e = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic ev_pulse(input int idx, input logic [7:0] bits);
    @(negedge clk);
    evt_set[idx*8 +: 8] = bits;
    @(negedge clk);
    evt_set = '0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(alert, 1'b0, "R1 alert after reset");
    chk(sys_rst_req, 1'b0, "R1 sys_rst_req after reset");
    rd(8'h06, 8'h00, "R1 key lo reset");
    rd(8'h07, 8'h00, "R1 key hi reset");
    rd(8'h08, 8'hC0, "R1 status reset");
    rd(8'h0A, 8'h00, "R1 event reset");

    // R2 constants and ignored writes
    rd(8'h00, 8'h03, "R2 boot minor");
    rd(8'h03, 8'h02, "R2 fw major");
    wr(8'h00, 8'hEE);
    rd(8'h00, 8'h03, "R2 write to constant ignored");
    wr(8'h08, 8'h00);
    rd(8'h08, 8'hC0, "R2 write to status ignored");

    // R9 unmapped reads
    rd(8'h0D, 8'h00, "R9 unmapped 0x0D");
    rd(8'h7F, 8'h00, "R9 unmapped 0x7F");
    rd(8'hFF, 8'h00, "R9 unmapped 0xFF");

    // R3 wrong pair: no request
    wr(8'h06, 8'h55);
    wr(8'h07, 8'hAB);
    for (int k = 0; k < 4; k++) begin
      chk(sys_rst_req, 1'b0, "R3 wrong key no reset");
      @(negedge clk);
    end
    rd(8'h06, 8'h55, "R3 key lo retained");

    // R3 correct pair, low first
    wr(8'h07, 8'hAA);
    chk(sys_rst_req, 1'b0, "R3 no pulse on write edge");
    @(negedge clk);
    chk(sys_rst_req, 1'b1, "R3 pulse after pair");
    @(negedge clk);
    chk(sys_rst_req, 1'b0, "R3 pulse one cycle");
    rd(8'h06, 8'h00, "R4 key lo wiped");
    rd(8'h07, 8'h00, "R4 key hi wiped");

    // R3 high first, R4 concurrent write discarded
    wr(8'h07, 8'hAA);
    wr(8'h06, 8'h55);
    wr_en = 1'b1; addr = 8'h06; wdata = 8'h12;
    @(negedge clk);
    wr_en = 1'b0;
    chk(sys_rst_req, 1'b1, "R3 pulse with high key first");
    rd(8'h06, 8'h00, "R4 write on fire edge discarded");

    // R5 R6 R7 events
    ev_pulse(2, 8'h10);
    chk(alert, 1'b1, "R7 alert on set");
    rd(8'h0B, 8'h10, "R6 event set");
    rd(8'h08, 8'hC4, "R5 status summary");
    wr(8'h0B, 8'h10);
    chk(alert, 1'b0, "R7 alert low when cleared");
    rd(8'h08, 8'hC0, "R5 status after clear");
    ev_pulse(0, 8'h05);
    wr(8'h09, 8'h01);
    rd(8'h09, 8'h04, "R6 partial clear");
    chk(alert, 1'b1, "R7 alert held with remaining bit");

    // R6 set versus clear collision on the same bit
    @(negedge clk);
    evt_set[15:8] = 8'h02;
    wr_en = 1'b1; addr = 8'h0A; wdata = 8'h02;
    @(negedge clk);
    evt_set = '0; wr_en = 1'b0;
    rd(8'h0A, 8'h02, "R6 set wins over clear");
    rd(8'h08, 8'hC3, "R5 two event flags");
    wr(8'h0A, 8'hFF);
    wr(8'h09, 8'hFF);
    chk(alert, 1'b0, "R7 alert low all cleared");

    // R8 ready flags
    @(negedge clk); api_start = 1'b1;
    @(negedge clk); api_start = 1'b0;
    rd(8'h08, 8'h80, "R8 api busy");
    @(negedge clk); api_done = 1'b1;
    @(negedge clk); api_done = 1'b0;
    rd(8'h08, 8'hC0, "R8 api ready again");
    @(negedge clk); api_start = 1'b1; api_done = 1'b1;
    @(negedge clk); api_start = 1'b0; api_done = 1'b0;
    rd(8'h08, 8'h80, "R8 api start wins");
    @(negedge clk); cmd_start = 1'b1; api_done = 1'b1;
    @(negedge clk); cmd_start = 1'b0; api_done = 1'b0;
    rd(8'h08, 8'h40, "R8 cmd busy");
    @(negedge clk); cmd_done = 1'b1;
    @(negedge clk); cmd_done = 1'b0;
    rd(8'h08, 8'hC0, "R8 cmd ready again");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule